// File: doc/BRIEF.md
# Mode-Programmable Byte Port with Service Request

This block is a byte-wide register port whose role is fixed by a static mode input. With mode low it is an **input port**. A peripheral strobes a byte into the register, and the port raises a service request toward the host. The host then reads the byte by selecting the port. With mode high it is an **output port**. The host writes the byte while the port is selected, and the service request tells the peripheral when fresh data is waiting.

The required polarity of the two chip selects depends on the mode. So do the output-enable policy and the meaning of the service-request pin. The output enable stands in for three-state drivers: when it is low, the data outputs read zero. Strobe, select and clear pass through a synchronizer chain in the fast system clock domain, and edges are detected after that chain. The data bus is sampled directly and must be stable while a write is in progress.

Top module: `byteport_top`

## Requirements
- R1: In mode 1, `dout_oe_o` is always 1. In mode 0, `dout_oe_o` is 1 exactly when `sel_a_i` and `sel_b_i` are both 1. Whenever `dout_oe_o` is 0, `dout_o` reads 0.
- R2: In mode 0, the register follows `din_i` while the strobe is high, whatever the selects are. It keeps its value once the strobe is low.
- R3: In mode 0, a falling edge of the strobe drives `srq_o` to 0 (request pending).
- R4: In mode 0, when the pair of selects stops being both high, `srq_o` returns to 1.
- R5: In mode 1, the register loads `din_i` only while `sel_a_i`=0, `sel_b_i`=1 and the strobe is high. Otherwise it holds its value.
- R6: In mode 1, `srq_o` goes to 1 when the port leaves the selected state (`sel_a_i`=0 and `sel_b_i`=1). It stays 1 until the next falling edge of the strobe, which returns it to 0 even while the port is deselected.
- R7: While clear is high, the register is zero and `srq_o` is idle: 1 in mode 0, 0 in mode 1.
- R8: Clear overrides a write that happens in the same cycle, and it also overrides a request set or release in that cycle.
- R9: After `rst_n` is released, the port is in the cleared state.
- R10: A strobe falling edge changes `srq_o` on the third system clock edge after the input changes, and not on the second.
- R11: In mode 0, if a strobe falling edge and a deselect arrive in the same cycle, the request is set and `srq_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all port inputs |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = input port, 1 = output port; change only under reset |
| strobe_i | input | 1 | Write strobe: transparent while high, holds on the falling edge |
| sel_a_i | input | 1 | First chip select (active 1 in mode 0, active 0 in mode 1) |
| sel_b_i | input | 1 | Second chip select, active high |
| clear_i | input | 1 | Clears the register and the request flag, active high |
| din_i | input | DATA_W | Data in |
| dout_o | output | DATA_W | Data out; reads 0 while the drivers are off |
| dout_oe_o | output | 1 | Output driver enable |
| srq_o | output | 1 | Service request; polarity depends on mode |

## Verification
The hardest cases to reach from the ports are same-cycle collisions. One is a strobe falling edge that lands in the same cycle as a deselect, or while clear is held. Another is a mode-1 request release caused by a strobe while the port is deselected. The bench drives these inputs on the same falling clock edge, so that they pass through the synchronizer together and reach the edge detector on one rising edge. Around them, the bench sweeps every select combination and a series of data patterns in both modes, with the mode changed only under reset.

// File: rtl/byteport_pkg.sv
package byteport_pkg;

    typedef enum logic {
        PORT_IN  = 1'b0,
        PORT_OUT = 1'b1
    } port_mode_e;

    // Control lines carried through the synchronizer, by position
    localparam int CTL_STRB  = 0;
    localparam int CTL_SEL_A = 1;
    localparam int CTL_SEL_B = 2;
    localparam int CTL_CLR   = 3;
    localparam int CTL_W     = 4;

endpackage

// File: rtl/byteport_sync.sv
module byteport_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/byteport_core.sv
module byteport_core
    import byteport_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              strb_s,
    input  logic              sel_a_s,
    input  logic              sel_b_s,
    input  logic              clr_s,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] data_o,
    output logic              flag_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              flag;   // 1 = request pending
        logic              strb;   // strobe seen last cycle
        logic              sel;    // mode-qualified select seen last cycle
    } core_st_t;

    core_st_t   st_d, st_q;
    port_mode_e mode;
    logic       sel_now, strb_fall, desel, wr, set_req, rel_req;

    always_comb begin
        mode      = port_mode_e'(mode_i);
        sel_now   = (mode == PORT_OUT) ? (!sel_a_s && sel_b_s) : (sel_a_s && sel_b_s);
        strb_fall = st_q.strb && !strb_s;
        desel     = st_q.sel && !sel_now;
        wr        = (mode == PORT_OUT) ? (sel_now && strb_s) : strb_s;
        set_req   = (mode == PORT_OUT) ? desel : strb_fall;
        rel_req   = (mode == PORT_OUT) ? strb_fall : desel;

        st_d      = st_q;
        st_d.strb = strb_s;
        st_d.sel  = sel_now;
        if (clr_s) begin
            st_d.data = '0;
            st_d.flag = 1'b0;
        end else begin
            if (wr) begin
                st_d.data = din_i;
            end
            if (set_req) begin
                st_d.flag = 1'b1;
            end else if (rel_req) begin
                st_d.flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;
    assign flag_o = st_q.flag;

endmodule

// File: rtl/byteport_drive.sv
module byteport_drive
    import byteport_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              mode_i,
    input  logic              sel_a_s,
    input  logic              sel_b_s,
    input  logic [DATA_W-1:0] data_i,
    input  logic              flag_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              oe_o,
    output logic              srq_o
);

    logic is_out;

    assign is_out = (port_mode_e'(mode_i) == PORT_OUT);
    assign oe_o   = is_out || (sel_a_s && sel_b_s);
    assign srq_o  = is_out ? flag_i : !flag_i;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign dout_o[i] = oe_o && data_i[i];
    end

endmodule

// File: rtl/byteport_top.sv
module byteport_top
    import byteport_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              strobe_i,
    input  logic              sel_a_i,
    input  logic              sel_b_i,
    input  logic              clear_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dout_oe_o,
    output logic              srq_o
);

    logic [CTL_W-1:0]  ctl_raw, ctl_s;
    logic              strb_s, sel_a_s, sel_b_s, clr_s;
    logic [DATA_W-1:0] data_q;
    logic              flag_q;

    always_comb begin
        ctl_raw            = '0;
        ctl_raw[CTL_STRB]  = strobe_i;
        ctl_raw[CTL_SEL_A] = sel_a_i;
        ctl_raw[CTL_SEL_B] = sel_b_i;
        ctl_raw[CTL_CLR]   = clear_i;
    end

    byteport_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (ctl_raw),
        .q_o  (ctl_s)
    );

    assign strb_s  = ctl_s[CTL_STRB];
    assign sel_a_s = ctl_s[CTL_SEL_A];
    assign sel_b_s = ctl_s[CTL_SEL_B];
    assign clr_s   = ctl_s[CTL_CLR];

    byteport_core #(.DATA_W(DATA_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_i),
        .strb_s (strb_s),
        .sel_a_s(sel_a_s),
        .sel_b_s(sel_b_s),
        .clr_s  (clr_s),
        .din_i  (din_i),
        .data_o (data_q),
        .flag_o (flag_q)
    );

    byteport_drive #(.DATA_W(DATA_W)) u_drive (
        .mode_i (mode_i),
        .sel_a_s(sel_a_s),
        .sel_b_s(sel_b_s),
        .data_i (data_q),
        .flag_i (flag_q),
        .dout_o (dout_o),
        .oe_o   (dout_oe_o),
        .srq_o  (srq_o)
    );

endmodule

// File: rtl/byteport_checker.sv
module byteport_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_i,
    input logic              s_strb,
    input logic              s_a,
    input logic              s_b,
    input logic              s_clr,
    input logic [DATA_W-1:0] data_q,
    input logic              flag_q,
    input logic [DATA_W-1:0] dout_o,
    input logic              dout_oe_o
);

    AST_OUTPORT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i |-> dout_oe_o);                                          // R1

    AST_OFF_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe_o |-> (dout_o == '0));                                 // R1

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        s_clr |=> (data_q == '0 && !flag_q));                           // R7

    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_strb && !s_clr) |=> $stable(data_q));                       // R2

    AST_IN_REQ_FROM_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && $rose(flag_q)) |-> ($past(!s_strb) && $past(s_strb, 2))); // R3

    AST_OUT_REQ_FROM_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && $rose(flag_q)) |-> $past(!(!s_a && s_b)));           // R6

    AST_OUT_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && $fell(flag_q)) |-> ($past(!s_strb) || $past(s_clr)));  // R6

endmodule

bind byteport_top byteport_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode_i),
    .s_strb   (strb_s),
    .s_a      (sel_a_s),
    .s_b      (sel_b_s),
    .s_clr    (clr_s),
    .data_q   (data_q),
    .flag_q   (flag_q),
    .dout_o   (dout_o),
    .dout_oe_o(dout_oe_o)
);

// File: tb/byteport_top_test.sv
module byteport_top_test;

    logic       clk = 1'b0;
    logic       rst_n, mode, strb, sel_a, sel_b, clr;
    logic [7:0] din, dout;
    logic       oe, srq;
    int         checks = 0;
    int         errors = 0;
    logic [7:0] exp_reg;

    always #5 clk = ~clk;

    byteport_top uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .strobe_i (strb),
        .sel_a_i  (sel_a),
        .sel_b_i  (sel_b),
        .clear_i  (clr),
        .din_i    (din),
        .dout_o   (dout),
        .dout_oe_o(oe),
        .srq_o    (srq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic m);
        rst_n = 1'b0; mode = m; strb = 1'b0; sel_a = 1'b0; sel_b = 1'b0;
        clr = 1'b0; din = 8'h00;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        // ---------------- input port ----------------
        do_reset(1'b0);
        chk("R9 oe", {31'd0, oe}, 0);
        chk("R9 dout", {24'd0, dout}, 0);
        chk("R9 srq", {31'd0, srq}, 1);

        for (int v = 0; v < 16; v++) begin
            logic [7:0] d;
            d = 8'((v * 37 + 11) & 255);
            din = d; strb = 1'b1; tick(3);
            strb = 1'b0; tick(3);
            chk("R3 srq low", {31'd0, srq}, 0);
            chk("R1 oe off", {31'd0, oe}, 0);
            sel_a = 1'b1; sel_b = 1'b1; tick(3);
            chk("R1 oe on", {31'd0, oe}, 1);
            chk("R2 latched", {24'd0, dout}, {24'd0, d});
            din = ~d; tick(3);
            chk("R2 hold", {24'd0, dout}, {24'd0, d});
            sel_b = 1'b0; tick(3);
            chk("R4 srq high", {31'd0, srq}, 1);
            chk("R1 dout zero", {24'd0, dout}, 0);
            sel_a = 1'b0; tick(1);
        end

        for (int ab = 0; ab < 4; ab++) begin
            sel_a = ab[1]; sel_b = ab[0]; tick(3);
            chk("R1 select sweep", {31'd0, oe}, {31'd0, ab[1] & ab[0]});
        end

        sel_a = 1'b1; sel_b = 1'b1; strb = 1'b1; din = 8'h3C; tick(3);
        chk("R2 transparent", {24'd0, dout}, 32'h3C);
        din = 8'hC3; tick(3);
        chk("R2 follows", {24'd0, dout}, 32'hC3);
        strb = 1'b0; tick(3);
        sel_b = 1'b0; tick(3);
        sel_b = 1'b1; tick(3);
        chk("R4 idle", {31'd0, srq}, 1);

        strb = 1'b1; tick(3);
        strb = 1'b0; tick(2);
        chk("R10 not yet", {31'd0, srq}, 1);
        tick(1);
        chk("R10 third edge", {31'd0, srq}, 0);

        clr = 1'b1; tick(3);
        chk("R7 dout", {24'd0, dout}, 0);
        chk("R7 srq", {31'd0, srq}, 1);
        strb = 1'b1; din = 8'hAA; tick(3);
        chk("R8 write blocked", {24'd0, dout}, 0);
        strb = 1'b0; tick(3);
        chk("R8 set blocked", {31'd0, srq}, 1);
        clr = 1'b0; tick(3);
        chk("R8 still zero", {24'd0, dout}, 0);

        strb = 1'b1; din = 8'h77; tick(3);
        strb = 1'b0; sel_a = 1'b0; tick(3);
        chk("R11 set wins", {31'd0, srq}, 0);
        sel_a = 1'b1; tick(3);
        chk("R11 data", {24'd0, dout}, 32'h77);

        // ---------------- output port ----------------
        do_reset(1'b1);
        chk("R9 oe m1", {31'd0, oe}, 1);
        chk("R9 dout m1", {24'd0, dout}, 0);
        chk("R9 srq m1", {31'd0, srq}, 0);

        exp_reg = 8'h00;
        for (int r = 0; r < 2; r++) begin
            for (int ab = 0; ab < 4; ab++) begin
                logic [7:0] d;
                d = 8'(16 + ab * 40 + r * 7);
                sel_a = ab[1]; sel_b = ab[0]; din = d; tick(1);
                strb = 1'b1; tick(3);
                strb = 1'b0; tick(3);
                if (!ab[1] && ab[0]) exp_reg = d;
                chk("R5 write gate", {24'd0, dout}, {24'd0, exp_reg});
                chk("R1 oe always", {31'd0, oe}, 1);
            end
        end

        sel_a = 1'b0; sel_b = 1'b1; tick(3);
        strb = 1'b1; din = 8'h5D; tick(3);
        strb = 1'b0; tick(3);
        exp_reg = 8'h5D;
        chk("R6 released", {31'd0, srq}, 0);
        sel_a = 1'b1; tick(3);
        chk("R6 set on deselect", {31'd0, srq}, 1);
        tick(5);
        chk("R6 stays", {31'd0, srq}, 1);
        din = 8'hE1; strb = 1'b1; tick(3);
        chk("R6 not on rise", {31'd0, srq}, 1);
        strb = 1'b0; tick(3);
        chk("R6 fall releases", {31'd0, srq}, 0);
        chk("R5 no write deselected", {24'd0, dout}, {24'd0, exp_reg});

        sel_a = 1'b0; tick(3);
        sel_a = 1'b1; tick(3);
        chk("R6 set again", {31'd0, srq}, 1);
        clr = 1'b1; tick(3);
        chk("R7 srq m1", {31'd0, srq}, 0);
        chk("R7 dout m1", {24'd0, dout}, 0);
        sel_a = 1'b0; tick(3);
        sel_a = 1'b1; tick(3);
        chk("R8 set blocked m1", {31'd0, srq}, 0);
        sel_a = 1'b0; strb = 1'b1; din = 8'h05; tick(3);
        chk("R8 write blocked m1", {24'd0, dout}, 0);
        strb = 1'b0; clr = 1'b0; tick(3);
        chk("R8 after clear", {24'd0, dout}, 0);

        finish_run();
    end

endmodule